// File: doc/BRIEF.md
# Three-Port Register File

This block is a general-purpose register file for a small processor core. It holds thirty-two 32-bit words. Two read ports can each look up any entry in the same cycle, and one write port updates a single entry per clock. Reads are combinational: a data output follows its address input with no clock delay. Writes commit on the rising clock edge.

Entry 0 is hard-wired to zero. Any write aimed at it is dropped, and both read ports always return zero for it. A synchronous reset clears every entry.

A parameter sets what a read returns when it hits the entry being written in the same cycle:

- `RD_OLD` returns the stored (old) value.
- `RD_NEW` forwards the incoming write data.

Top module: `regfile_3p`

## Requirements
- R1: While `rst` is high at a rising clock edge, every entry is cleared. After reset, every address 0 to 31 reads as 0 on both ports.
- R2: When `wr_en` is high at a rising clock edge and `wr_addr` is not 0, entry `wr_addr` takes `wr_data`. A read of that entry returns the new value from just after that edge.
- R3: When `wr_en` is low at a rising edge, no entry changes, whatever `wr_addr` and `wr_data` hold.
- R4: Address 0 always reads as 32'h0 on both read ports, in both read policies.
- R5: A write to address 0 has no effect: address 0 still reads 0, and all other entries keep their values.
- R6: The two read ports are independent. Each returns the entry at its own address, and both return the same value when given the same address.
- R7: Reads are combinational. A change of a read address changes the read data within the same cycle, with no clock edge in between.
- R8: In a cycle where a read address equals a nonzero `wr_addr` with `wr_en` high, the read returns the old stored value under `RD_OLD` (the default) and `wr_data` under `RD_NEW`.
- R9: Reset has priority over a write in the same cycle. An entry written while `rst` is high reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Destination entry number |
| wr_data | input | 32 | Value to write |
| rd_a_addr | input | 5 | Read port A entry number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 5 | Read port B entry number |
| rd_b_data | output | 32 | Read port B data |

## Verification
The bench builds two copies of the file with the default 32 entries of 32 bits. One copy uses `RD_OLD` and the other uses `RD_NEW`. Both copies share every input, so a single read-during-write cycle shows the old value on one copy and the forwarded value on the other. The same setup shows that forwarding never leaks a write into entry 0. With the full default depth, every address from 0 to 31 is compared against a reference array on both ports.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    // What a read sees when it addresses the entry being written this cycle
    typedef enum logic {
        RD_OLD = 1'b0,
        RD_NEW = 1'b1
    } rd_policy_e;

endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
    parameter int NUM_REGS = 32,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    output logic [NUM_REGS-1:0] wr_sel
);

    // Entry 0 is never selected; reset blocks every select
    assign wr_sel[0] = 1'b0;

    for (genvar i = 1; i < NUM_REGS; i++) begin : g_sel
        assign wr_sel[i] = wr_en && !rst && (wr_addr == ADDR_W'(i));
    end

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [NUM_REGS-1:0]                wr_sel,
    input  logic [DATA_W-1:0]                  wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]    regs_o
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_sel[i]) begin
                st_d.regs[i] = wr_data;
            end
        end
        st_d.regs[0] = '0;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign regs_o = st_q;

    // R2: an enabled write to a nonzero entry lands on the next edge
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != '0) |=> (st_q.regs[$past(wr_addr)] == $past(wr_data)));

    // R3: without a write select nothing moves
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == '0) |=> (st_q == $past(st_q)));

    // R5: entry 0 never holds anything but zero
    a_r5_zero_entry: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == '0) |=> (st_q.regs[0] == '0));

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import regfile_pkg::*;
#(
    parameter int         NUM_REGS = 32,
    parameter int         DATA_W   = 32,
    parameter rd_policy_e POLICY   = RD_OLD,
    localparam int        ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
    input  logic [NUM_REGS-1:0]             wr_sel,
    input  logic [DATA_W-1:0]               wr_data,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic [DATA_W-1:0]               rd_data
);

    logic [DATA_W-1:0] stored;
    logic              hit;

    always_comb begin
        stored = '0;
        hit    = 1'b0;
        if (rd_addr != '0 && int'(rd_addr) < NUM_REGS) begin
            stored = regs_i[rd_addr];
            hit    = wr_sel[rd_addr];
        end
    end

    if (POLICY == RD_NEW) begin : g_fwd
        assign rd_data = hit ? wr_data : stored;
    end else begin : g_old
        logic unused_hit;
        assign unused_hit = hit;
        assign rd_data    = stored;
    end

endmodule

// File: rtl/regfile_3p.sv
module regfile_3p
    import regfile_pkg::*;
#(
    parameter int         NUM_REGS = 32,
    parameter int         DATA_W   = 32,
    parameter rd_policy_e POLICY   = RD_OLD,
    localparam int        ADDR_W   = $clog2(NUM_REGS),
    localparam int        NUM_RD   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data
);

    logic [NUM_REGS-1:0]             wr_sel;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic [NUM_RD-1:0][ADDR_W-1:0]   rd_addr;
    logic [NUM_RD-1:0][DATA_W-1:0]   rd_data;

    rf_wr_decode #(.NUM_REGS(NUM_REGS)) u_dec (
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_sel  (wr_sel)
    );

    rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .regs_o  (regs)
    );

    assign rd_addr[0] = rd_a_addr;
    assign rd_addr[1] = rd_b_addr;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rf_read_port #(
            .NUM_REGS (NUM_REGS),
            .DATA_W   (DATA_W),
            .POLICY   (POLICY)
        ) u_port (
            .regs_i  (regs),
            .wr_sel  (wr_sel),
            .wr_data (wr_data),
            .rd_addr (rd_addr[p]),
            .rd_data (rd_data[p])
        );
    end

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];

    // R4: entry 0 reads zero on either port
    a_r4_zero_port_a: assert property (@(posedge clk) disable iff (rst)
        (rd_a_addr == '0) |-> (rd_a_data == '0));
    a_r4_zero_port_b: assert property (@(posedge clk) disable iff (rst)
        (rd_b_addr == '0) |-> (rd_b_data == '0));

    // R6: both ports agree on a shared address
    a_r6_ports_agree: assert property (@(posedge clk) disable iff (rst)
        (rd_a_addr == rd_b_addr) |-> (rd_a_data == rd_b_data));

    // R8: under forwarding, a hit returns the incoming data
    if (POLICY == RD_NEW) begin : g_fwd_chk
        a_r8_forward_hit: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr != '0 && wr_addr == rd_a_addr) |-> (rd_a_data == wr_data));
    end else begin : g_old_chk
        a_r8_old_hit: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr != '0 && wr_addr == rd_a_addr && $stable(rd_a_addr))
            |-> (rd_a_data == $past(rd_a_data) || $past(wr_en)));
    end

endmodule

// File: tb/test_regfile_3p.sv
module test_regfile_3p;
    import regfile_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_a_addr = '0;
    logic [4:0]  rd_b_addr = '0;
    logic [31:0] a_old, b_old, a_new, b_new;

    logic [31:0] ref_mem [32];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    regfile_3p i_regfile_3p (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_a_addr(rd_a_addr), .rd_a_data(a_old), .rd_b_addr(rd_b_addr), .rd_b_data(b_old)
    );

    regfile_3p #(.POLICY(RD_NEW)) i_regfile_3p_fwd (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_a_addr(rd_a_addr), .rd_a_data(a_new), .rd_b_addr(rd_b_addr), .rd_b_data(b_new)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Advance one edge; inputs change 1 ns after the edge, outputs are sampled before the next
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_write(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        if (a != 0) ref_mem[a] = d;
        wr_en = 1'b0;
    endtask

    task automatic check_all(input string req);
        int errs = 0;
        for (int i = 0; i < 32; i++) begin
            rd_a_addr = 5'(i);
            rd_b_addr = 5'(31 - i);
            #0.5;
            if (a_old !== ref_mem[i] || b_old !== ref_mem[31 - i] ||
                a_new !== ref_mem[i] || b_new !== ref_mem[31 - i]) errs++;
        end
        chk(req, 32'(errs), 32'd0);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 32; i++) ref_mem[i] = '0;
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        check_all("R1 reset clears all");
        do_write(5'd5, 32'hDEAD_BEEF);
        // R9: write while reset is high
        rst = 1'b1; wr_en = 1'b1; wr_addr = 5'd5; wr_data = 32'h1234_5678;
        tick();
        rst = 1'b0; wr_en = 1'b0;
        ref_mem[5] = '0;
        rd_a_addr = 5'd5; #0.5;
        chk("R9 reset beats write", a_old, 32'h0);
        chk("R9 reset beats write fwd", a_new, 32'h0);
    endtask

    task automatic t_write_read();
        for (int i = 1; i < 32; i++) do_write(5'(i), (32'(i) * 32'h0101_0101) ^ 32'hA5A5_0F0F);
        check_all("R2 R6 write then read both ports");
        do_write(5'd31, 32'hFFFF_FFFF);
        rd_a_addr = 5'd31; #0.5;
        chk("R2 top entry", a_old, 32'hFFFF_FFFF);
    endtask

    task automatic t_hold();
        wr_en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            wr_addr = 5'(i * 4 + 1);
            wr_data = 32'hBAD0_0000 | 32'(i);
            tick();
        end
        check_all("R3 disabled writes ignored");
    endtask

    task automatic t_zero();
        for (int i = 0; i < 3; i++) do_write(5'd0, 32'hFFFF_0000 + 32'(i));
        rd_a_addr = 5'd0; rd_b_addr = 5'd0; #0.5;
        chk("R4 port A zero", a_old, 32'h0);
        chk("R4 port B zero", b_old, 32'h0);
        chk("R5 fwd copy zero", a_new | b_new, 32'h0);
        check_all("R5 other entries untouched");
    endtask

    task automatic t_same();
        rd_a_addr = 5'd17; rd_b_addr = 5'd17; #0.5;
        chk("R6 same addr port A", a_old, ref_mem[17]);
        chk("R6 same addr port B", b_old, ref_mem[17]);
    endtask

    task automatic t_comb();
        rd_a_addr = 5'd3; #0.5;
        chk("R7 first addr", a_old, ref_mem[3]);
        rd_a_addr = 5'd9; #0.5;
        chk("R7 addr change same cycle", a_old, ref_mem[9]);
    endtask

    task automatic t_rdw();
        wr_en = 1'b1; wr_addr = 5'd7; wr_data = 32'hC0FF_EE07;
        rd_a_addr = 5'd7; rd_b_addr = 5'd7; #0.5;
        chk("R8 old policy port A", a_old, ref_mem[7]);
        chk("R8 new policy port A", a_new, 32'hC0FF_EE07);
        chk("R8 new policy port B", b_new, 32'hC0FF_EE07);
        tick();
        ref_mem[7] = 32'hC0FF_EE07;
        wr_en = 1'b0; #0.5;
        chk("R8 old policy after edge", a_old, 32'hC0FF_EE07);
        // Forwarding must not apply to entry 0
        wr_en = 1'b1; wr_addr = 5'd0; wr_data = 32'h5555_AAAA;
        rd_a_addr = 5'd0; #0.5;
        chk("R4 no forward into entry 0", a_new, 32'h0);
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        #1;
        t_reset();
        t_write_read();
        t_hold();
        t_zero();
        t_same();
        t_comb();
        t_rdw();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

endmodule